// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of an SDRAM read or write burst. A one-cycle start pulse loads a starting column, a burst length code and a burst type. From the next cycle on, the block presents one column address per clock together with a beat-valid flag. It raises a last-beat flag on the final beat of the burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block that holds the starting column. Linear ordering counts upward and wraps at the edge of that block. Interleaved ordering XORs the beat index into the low address bits. A full-page burst walks through the whole row, wraps past the top column and continues until a stop request ends it. A stop request ends any burst early.

A start pulse may arrive on any beat, including the last one. The next burst then follows with no idle cycle. Command generation, data capture, read latency and the bank and row fields belong to neighbouring logic.

Top module: `colseq_top`

## Requirements
- R1: While reset is held and on the first cycle after it is released, with no start pulse given, `beat_vld_o` and `last_o` are 0.
- R2: A start pulse sampled at a clock edge makes the next cycle beat 0, with `beat_vld_o`=1 and `col_o` equal to the sampled `start_col_i`. Length codes: 0 means 1 beat, 1 means 2, 2 means 4, 3 means 8 and 7 means full page.
- R3: In a linear fixed burst of length L, beat i has its low log2(L) bits equal to (start low bits + i) mod L. The upper bits stay equal to those of the start column.
- R4: In an interleaved (`ilv_i`=1) fixed burst, beat i has its low log2(L) bits equal to (start low bits XOR i). The upper bits stay equal to those of the start column.
- R5: In a full-page burst, beat i is (start + i) mod 2^COL_W in either burst type. The burst continues past the wrap, and `last_o` is raised only by a stop request.
- R6: A fixed burst gives exactly L beats, and `last_o`=1 only on the final one. With no new start, `beat_vld_o` is 0 on the cycle after the final beat.
- R7: When `stop_i` is 1 during a beat, that beat shows `last_o`=1 and no further beats follow. When `stop_i` is 1 with no burst in progress, the outputs are unaffected.
- R8: A start pulse given during a beat, including the final one, makes the next cycle beat 0 of the new burst, with no idle cycle between the bursts.
- R9: The reserved length codes 4, 5 and 6 give a single-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that loads a new burst |
| start_col_i | input | COL_W | Starting column, sampled with start_i |
| len_code_i | input | 3 | Burst length code, sampled with start_i |
| ilv_i | input | 1 | Burst type: 1 selects interleaved, 0 selects linear; sampled with start_i |
| stop_i | input | 1 | Ends the burst on the current beat |
| col_o | output | COL_W | Column address of the current beat |
| beat_vld_o | output | 1 | A beat is being presented |
| last_o | output | 1 | The current beat is the final one |

## Verification
The assertions assume that `start_col_i`, `len_code_i` and `ilv_i` are stable and meaningful whenever `start_i` is high. They assume nothing about `stop_i`, which may arrive on any cycle, including one with no burst. The bench changes inputs only on the falling clock edge. It holds the burst fields steady for the whole cycle in which it raises the start pulse, and it drops the pulse before the next falling edge unless it is testing back-to-back bursts. Bursts cover every length code, both burst types, unaligned start columns, full-page runs that cross the row wrap, stops in the middle of a burst and on an idle cycle, and a chained start on a final beat.

// File: rtl/colseq_pkg.sv
// colseq_pkg: shared length codes for the burst column sequencer.
// Assumes a 3-bit length code; codes not listed here mean a single beat.
package colseq_pkg;
    localparam int LEN_CODE_W = 3;
    typedef enum logic [LEN_CODE_W-1:0] {
        LEN_1    = 3'd0,
        LEN_2    = 3'd1,
        LEN_4    = 3'd2,
        LEN_8    = 3'd3,
        LEN_PAGE = 3'd7
    } len_code_e;
endpackage

// File: rtl/colseq_mask.sv
// colseq_mask: turns a latched length code into the mask of address bits
// that change during the burst, and flags full-page mode.
// Assumes COL_W >= 3 so that an 8-beat block fits in the column field.
module colseq_mask
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [LEN_CODE_W-1:0] code_i,
    output logic [COL_W-1:0]      mask_o,
    output logic                  full_o
);
    localparam logic [COL_W-1:0] ONE = COL_W'(1);

    // Decode the length code into a low-bit mask; reserved codes give one beat.
    always_comb begin
        full_o = 1'b0;
        unique case (code_i)
            LEN_1, LEN_2, LEN_4, LEN_8: mask_o = (ONE << code_i) - ONE;
            LEN_PAGE: begin
                mask_o = '1;
                full_o = 1'b1;
            end
            default:  mask_o = '0;
        endcase
    end
endmodule

// File: rtl/colseq_ctrl.sv
// colseq_ctrl: holds the burst state (start column, type, length code,
// beat counter) and decides the final beat.
// Assumes the start fields are valid when start_i is high; start wins over stop.
module colseq_ctrl
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  ilv_i,
    input  logic                  stop_i,
    input  logic [COL_W-1:0]      mask_i,
    input  logic                  full_i,
    output logic                  active_o,
    output logic [COL_W-1:0]      cnt_o,
    output logic [COL_W-1:0]      base_o,
    output logic                  ilv_o,
    output logic [LEN_CODE_W-1:0] code_o,
    output logic                  last_o
);
    // Final beat: a stop, or a fixed burst whose count reached its mask.
    always_comb begin
        last_o = active_o & (stop_i | (~full_i & (cnt_o == mask_i)));
    end

    // Load on start, step while active, go idle after the final beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_o <= 1'b0;
            cnt_o    <= '0;
            base_o   <= '0;
            ilv_o    <= 1'b0;
            code_o   <= LEN_1;
        end else if (start_i) begin
            active_o <= 1'b1;
            cnt_o    <= '0;
            base_o   <= start_col_i;
            ilv_o    <= ilv_i;
            code_o   <= len_code_i;
        end else if (active_o) begin
            if (last_o) begin
                active_o <= 1'b0;
            end else begin
                cnt_o <= cnt_o + COL_W'(1);
            end
        end
    end

    // R6
    // After a final beat with no new start, the burst is over.
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && !start_i) |=> !active_o);

    // R7
    // A stop during a beat leaves no further beats unless a start follows.
    stop_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && stop_i && !start_i) |=> !active_o);

    // R2
    // A start always opens a burst at beat zero.
    start_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (active_o && cnt_o == '0 && base_o == $past(start_col_i)));

    // R6
    // The final-beat flag never shows without a beat.
    last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> active_o);
endmodule

// File: rtl/colseq_addr.sv
// colseq_addr: forms the column address of the current beat from the start
// column, the beat index and the burst mask, for linear, interleaved and
// full-page ordering.
// Assumes the mask covers a contiguous run of low bits.
module colseq_addr #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             active_i,
    input  logic             last_i,
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] cnt_i,
    input  logic [COL_W-1:0] mask_i,
    input  logic             full_i,
    input  logic             ilv_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] lin_sum;
    logic [COL_W-1:0] low_bits;

    // Pick the low bits by ordering and keep the upper bits of the start column.
    always_comb begin
        lin_sum  = base_i + cnt_i;
        low_bits = (ilv_i && !full_i) ? (base_i ^ cnt_i) : lin_sum;
        col_o    = (base_i & ~mask_i) | (low_bits & mask_i);
    end

    // R3
    // Within a fixed burst the bits above the mask do not move.
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !last_i && !start_i && !full_i)
            |=> ((col_o & ~mask_i) == $past(col_o & ~mask_i)));

    // R3
    // Linear ordering advances the masked bits by one, wrapping in the block.
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !last_i && !start_i && !ilv_i && !full_i)
            |=> ((col_o & mask_i) == (($past(col_o) + COL_W'(1)) & mask_i)));

    // R4
    // Interleaved ordering: the masked bits equal the start bits XOR the index.
    ilv_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && ilv_i && !full_i)
            |-> (((col_o ^ base_i) & mask_i) == (cnt_i & mask_i)));

    // R5
    // Full page steps by one modulo the row size.
    page_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !last_i && !start_i && full_i)
            |=> (col_o == $past(col_o) + COL_W'(1)));
endmodule

// File: rtl/colseq_top.sv
// colseq_top: SDRAM burst column address sequencer. A start pulse loads a
// burst; one column address per clock follows, with valid and last flags.
// Assumes start fields are stable while start_i is high. Reset is synchronous, active low.
module colseq_top
    import colseq_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  ilv_i,
    input  logic                  stop_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  beat_vld_o,
    output logic                  last_o
);
    logic                  active;
    logic [COL_W-1:0]      cnt;
    logic [COL_W-1:0]      base;
    logic                  ilv_q;
    logic [LEN_CODE_W-1:0] code_q;
    logic [COL_W-1:0]      mask;
    logic                  full;

    colseq_mask #(.COL_W(COL_W)) mask_i (
        .code_i (code_q),
        .mask_o (mask),
        .full_o (full)
    );

    colseq_ctrl #(.COL_W(COL_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_code_i  (len_code_i),
        .ilv_i       (ilv_i),
        .stop_i      (stop_i),
        .mask_i      (mask),
        .full_i      (full),
        .active_o    (active),
        .cnt_o       (cnt),
        .base_o      (base),
        .ilv_o       (ilv_q),
        .code_o      (code_q),
        .last_o      (last_o)
    );

    colseq_addr #(.COL_W(COL_W)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .active_i (active),
        .last_i   (last_o),
        .base_i   (base),
        .cnt_i    (cnt),
        .mask_i   (mask),
        .full_i   (full),
        .ilv_i    (ilv_q),
        .col_o    (col_o)
    );

    // Valid follows the burst state directly.
    always_comb begin
        beat_vld_o = active;
    end

    // R1
    // The cycle after reset carries no beat.
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!beat_vld_o && !last_o));
endmodule

// File: tb/colseq_top_tb.sv
// colseq_top_tb_top: table-driven bench for the burst column sequencer,
// followed by directed checks for reset, idle stop and chained bursts.
module colseq_top_tb_top;
    localparam int COL_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             ilv_i = 1'b0;
    logic             stop_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             beat_vld_o;
    logic             last_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    colseq_top #(.COL_W(COL_W)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .len_code_i  (len_code_i),
        .ilv_i       (ilv_i),
        .stop_i      (stop_i),
        .col_o       (col_o),
        .beat_vld_o  (beat_vld_o),
        .last_o      (last_o)
    );

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Vector: start column, length code, interleave, stop index (-1 = none).
    typedef struct packed {
        logic [7:0] col;
        logic [2:0] code;
        logic       ilv;
        int         stop_at;
    } vec_t;

    localparam int NVEC = 12;
    localparam vec_t VECS [NVEC] = '{
        '{8'h00, 3'd0, 1'b0, -1},   // R2 single beat
        '{8'h13, 3'd1, 1'b0, -1},   // R3 len 2 linear, odd start
        '{8'h46, 3'd2, 1'b0, -1},   // R3 len 4 wrap in block
        '{8'h2D, 3'd3, 1'b0, -1},   // R3 len 8 linear
        '{8'h13, 3'd1, 1'b1, -1},   // R4 len 2 interleaved
        '{8'h46, 3'd2, 1'b1, -1},   // R4 len 4 interleaved
        '{8'hF5, 3'd3, 1'b1, -1},   // R4 len 8 interleaved
        '{8'hFA, 3'd7, 1'b0, 9},    // R5 full page across wrap
        '{8'h05, 3'd7, 1'b1, 259},  // R5 full page, beyond a whole row
        '{8'h3C, 3'd3, 1'b1, 2},    // R7 stop inside a fixed burst
        '{8'h81, 3'd5, 1'b0, -1},   // R9 reserved code
        '{8'h77, 3'd6, 1'b1, -1}    // R9 reserved code
    };

    function automatic int beats_of(input logic [2:0] code);
        case (code)
            3'd1: return 2;
            3'd2: return 4;
            3'd3: return 8;
            default: return 1;
        endcase
    endfunction

    // Expected address of beat i, from the ordering requirements.
    function automatic logic [7:0] exp_col(input logic [7:0] sc, input logic [2:0] code,
                                           input logic il, input int i);
        logic [7:0] m;
        logic [7:0] ib;
        ib = 8'(i);
        if (code == 3'd7) return sc + ib;
        m = 8'(beats_of(code) - 1);
        if (il) return (sc & ~m) | ((sc ^ ib) & m);
        return (sc & ~m) | ((sc + ib) & m);
    endfunction

    function automatic string tag_of(input logic [2:0] code, input logic il);
        if (code == 3'd7) return "R5";
        if (code inside {3'd4, 3'd5, 3'd6}) return "R9";
        if (il) return "R4";
        return "R3";
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue a start on the next falling edge; beat 0 shows after the rising edge.
    task automatic launch(input logic [7:0] sc, input logic [2:0] code, input logic il);
        @(negedge clk);
        start_i = 1'b1;
        start_col_i = sc;
        len_code_i = code;
        ilv_i = il;
        @(posedge clk);
    endtask

    task automatic run_burst(input vec_t v);
        int n;
        bit fin;
        n = (v.code == 3'd7) ? v.stop_at + 1 : beats_of(v.code);
        if (v.stop_at >= 0 && v.stop_at + 1 < n) n = v.stop_at + 1;
        launch(v.col, v.code, v.ilv);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            stop_i = (i == v.stop_at);
            #1;
            fin = (i == n - 1);
            if (i == 0) check("R2", "beat0 col", col_o, v.col);
            check(tag_of(v.code, v.ilv), "col", col_o, exp_col(v.col, v.code, v.ilv, i));
            check("R6", "vld", beat_vld_o, 1);
            check(v.stop_at >= 0 ? "R7" : "R6", "last", last_o, fin);
            if (!fin) @(posedge clk);
        end
        @(posedge clk);
        @(negedge clk);
        stop_i = 1'b0;
        #1;
        check(v.stop_at >= 0 ? "R7" : "R6", "vld after end", beat_vld_o, 0);
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "vld in reset", beat_vld_o, 0);
        check("R1", "last in reset", last_o, 0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", "vld after reset", beat_vld_o, 0);
        check("R1", "last after reset", last_o, 0);

        // R7: stop on an idle cycle leaves outputs quiet
        stop_i = 1'b1;
        #1;
        check("R7", "idle stop last", last_o, 0);
        @(posedge clk);
        @(negedge clk);
        stop_i = 1'b0;
        check("R7", "idle stop vld", beat_vld_o, 0);

        foreach (VECS[k]) run_burst(VECS[k]);

        // R8: chain a new burst on the final beat of a linear len-4 burst
        launch(8'h10, 3'd2, 1'b0);
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            start_i = 1'b0;
            #1;
            check("R8", "first burst col", col_o, 8'h10 + 8'(i));
            if (i == 3) begin
                check("R8", "first burst last", last_o, 1);
                start_i = 1'b1;
                start_col_i = 8'h23;
                len_code_i = 3'd1;
                ilv_i = 1'b1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check("R8", "chained beat0 vld", beat_vld_o, 1);
        check("R8", "chained beat0 col", col_o, 8'h23);
        check("R8", "chained beat0 last", last_o, 0);
        @(posedge clk);
        @(negedge clk);
        check("R8", "chained beat1 col", col_o, 8'h22);
        check("R8", "chained beat1 last", last_o, 1);
        @(posedge clk);
        @(negedge clk);
        check("R8", "idle after chain", beat_vld_o, 0);

        // R8: start in mid-burst restarts at beat 0 of the new burst
        launch(8'h40, 3'd3, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b1;
        start_col_i = 8'h9E;
        len_code_i = 3'd0;
        ilv_i = 1'b0;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check("R8", "restart col", col_o, 8'h9E);
        check("R8", "restart last", last_o, 1);

        @(posedge clk);
        @(negedge clk);
        check("R6", "final idle", beat_vld_o, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule